// File: doc/BRIEF.md
# Hybrid Snoop-Miss Filter

This block sits next to the tag array of a private cache and, for every snooped bus address, decides whether the tag lookup can be skipped because the block is surely absent. It never skips a snoop for a resident block. It may still send some absent blocks to the tags.

Two structures are probed in parallel. The first is a presence summary. Several banks of small counters, each bank indexed by a different slice of the block address, are raised on every fill and lowered on every eviction. If any indexed counter is zero, the block cannot be cached. The second is a small fully associative table of addresses whose snoops recently missed in the tags. A hit in that table also skips the lookup.

The surrounding logic reports each tag-lookup result back to the block. A miss that the presence summary could not have caught is then recorded in the table. Fills remove matching table entries, so a newly cached block is always forwarded.

Top module: `snoop_miss_filter`

## Requirements
- R1: After reset all counters are zero and the table is empty, so every snoop asserts `snp_skip` until the first fill.
- R2: The skip decision is combinational in the cycle of the snoop, and state updates are visible from the next cycle. A block that has been filled and not yet evicted is always forwarded (`snp_skip`=0).
- R3: Counter bank k (k=0,1,2) is indexed by block-address bits [3k+4:3k], so neighbouring slices overlap by two bits. A snoop is skipped when any of its three counters is zero. An address that aliases a resident block in all three slices is forwarded.
- R4: An eviction lowers the three counters of the evicted block. After all aliasing blocks have left, the address is skipped again.
- R5: Counters are 2 bits wide and saturate at 3. A counter that reaches 3 stays at 3 through later evictions and never wraps.
- R6: A tag result with `tag_hit`=0 allocates its address in the table only while the presence summary reports "may be cached" for it. A table hit skips later snoops to that address.
- R7: A tag result with `tag_hit`=1 allocates nothing, and later snoops to that address are still forwarded.
- R8: A fill clears any table entry holding the same address. A snoop in the same cycle as a fill of the same block is forwarded. A tag miss in the same cycle as a fill of the same block allocates nothing.
- R9: The table has 4 entries and is replaced round-robin. The pointer starts at slot 0 after reset, advances only when an entry is written, and does not prefer free slots.
- R10: A tag miss for an address already held in the table writes nothing and does not advance the pointer.
- R11: `snp_skip` is 0 whenever `snp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snp_valid | input | 1 | A snoop is presented this cycle |
| snp_addr | input | 16 | Block address of the snoop |
| snp_skip | output | 1 | 1: tag lookup may be skipped for this snoop |
| fill_valid | input | 1 | A block is allocated in the cache |
| fill_addr | input | 16 | Block address of the fill |
| evict_valid | input | 1 | A block leaves the cache |
| evict_addr | input | 16 | Block address of the eviction |
| tag_valid | input | 1 | Result of a forwarded snoop's tag lookup |
| tag_addr | input | 16 | Block address of that lookup |
| tag_hit | input | 1 | 1: the lookup hit in the tags |

## Verification
A counter that drops too low or wraps appears at the port as a skip for a resident block, one cycle after the eviction that caused it. A stale table entry shows up as a skip on the first snoop after a fill of that block. A pointer that moves when it should not, or moves in the wrong order, only shows after several further allocations, when the wrong victim starts being forwarded. The bench therefore fills the table past its capacity and then probes every surviving entry.

// File: rtl/smf_pkg.sv
package smf_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2
  } cnt_act_e;

  // Simultaneous raise and lower of one counter cancel out.
  function automatic cnt_act_e cnt_action(input logic inc, input logic dec);
    if (inc && !dec) return CNT_UP;
    if (dec && !inc) return CNT_DOWN;
    return CNT_HOLD;
  endfunction

endpackage

// File: rtl/smf_include.sv
module smf_include #(
  parameter int ADDR_W   = 16,
  parameter int NUM_HASH = 3,
  parameter int IDX_W    = 5,
  parameter int STRIDE   = 3,
  parameter int CNT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_v,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              evict_v,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ADDR_W-1:0] tag_addr,
  output logic              snp_maybe,
  output logic              tag_maybe
);
  import smf_pkg::*;

  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Slice k of the block address selects the counter in bank k.
  function automatic logic [IDX_W-1:0] hidx(input logic [ADDR_W-1:0] a, input int k);
    return a[k*STRIDE +: IDX_W];
  endfunction

  // Saturating step: a full counter is sticky, an empty one never underflows.
  function automatic logic [CNT_W-1:0] next_cnt(input logic [CNT_W-1:0] cur, input cnt_act_e act);
    case (act)
      CNT_UP:   return (cur == CNT_MAX) ? cur : cur + 1'b1;
      CNT_DOWN: return (cur == CNT_MAX || cur == '0) ? cur : cur - 1'b1;
      default:  return cur;
    endcase
  endfunction

  logic [CNT_W-1:0]    cnt_q [NUM_HASH][DEPTH];
  logic [IDX_W-1:0]    fidx  [NUM_HASH];
  logic [IDX_W-1:0]    eidx  [NUM_HASH];
  logic [IDX_W-1:0]    sidx  [NUM_HASH];
  logic [IDX_W-1:0]    tidx  [NUM_HASH];
  logic [NUM_HASH-1:0] snp_bit;
  logic [NUM_HASH-1:0] tag_bit;

  for (genvar k = 0; k < NUM_HASH; k++) begin : g_bank
    assign fidx[k]    = hidx(fill_addr, k);
    assign eidx[k]    = hidx(evict_addr, k);
    assign sidx[k]    = hidx(snp_addr, k);
    assign tidx[k]    = hidx(tag_addr, k);
    assign snp_bit[k] = (cnt_q[k][sidx[k]] != '0);
    assign tag_bit[k] = (cnt_q[k][tidx[k]] != '0);

    // R2: a filled block finds a non-zero counter in every bank next cycle.
    assert_fill_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fill_v |=> (cnt_q[k][$past(fidx[k])] != '0));

    for (genvar j = 0; j < DEPTH; j++) begin : g_cnt
      // R5: a saturated counter never leaves saturation.
      assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q[k][j] == CNT_MAX) |=> (cnt_q[k][j] == CNT_MAX));
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_HASH; k++) begin
      for (int j = 0; j < DEPTH; j++) begin
        if (!rst_n) begin
          cnt_q[k][j] <= '0;
        end else begin
          cnt_q[k][j] <= next_cnt(cnt_q[k][j],
                                  cnt_action(fill_v  && (fidx[k] == IDX_W'(j)),
                                             evict_v && (eidx[k] == IDX_W'(j))));
        end
      end
    end
  end

  assign snp_maybe = &snp_bit;
  assign tag_maybe = &tag_bit;

endmodule

// File: rtl/smf_exclude.sv
module smf_exclude #(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_hit,
  input  logic              fill_v,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              alloc_req,
  input  logic [ADDR_W-1:0] alloc_addr
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(ENTRIES-1)) ? '0 : p + 1'b1;
  endfunction

  logic [ENTRIES-1:0] valid_q;
  logic [ADDR_W-1:0]  tag_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q;
  logic [ENTRIES-1:0] probe_match;
  logic [ENTRIES-1:0] alloc_match;
  logic [ENTRIES-1:0] fill_match;
  logic               alloc_en;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign probe_match[e] = valid_q[e] && (tag_q[e] == probe_addr);
    assign alloc_match[e] = valid_q[e] && (tag_q[e] == alloc_addr);
    assign fill_match[e]  = valid_q[e] && (tag_q[e] == fill_addr);

    // R8: an entry matching a fill is gone next cycle unless it was rewritten.
    assert_fill_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_v && fill_match[e] && !(alloc_en && ptr_q == PTR_W'(e))) |=> !valid_q[e]);
  end

  assign probe_hit = |probe_match;
  assign alloc_en  = alloc_req && !(|alloc_match);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
      for (int e = 0; e < ENTRIES; e++) tag_q[e] <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (alloc_en && ptr_q == PTR_W'(e)) begin
          valid_q[e] <= 1'b1;
          tag_q[e]   <= alloc_addr;
        end else if (fill_v && fill_match[e]) begin
          valid_q[e] <= 1'b0;
        end
      end
      if (alloc_en) ptr_q <= next_ptr(ptr_q);
    end
  end

  // R6: a written entry holds the allocated address.
  assert_alloc_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> (valid_q[$past(ptr_q)] && tag_q[$past(ptr_q)] == $past(alloc_addr)));

  // R9: the pointer moves one step per write and holds otherwise.
  assert_rr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> (ptr_q == next_ptr($past(ptr_q))));
  assert_rr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_en |=> $stable(ptr_q));

  // R10: an allocated address occupies at most one entry.
  assert_no_dup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_req |=> $onehot0(alloc_match));

endmodule

// File: rtl/snoop_miss_filter.sv
module snoop_miss_filter #(
  parameter int ADDR_W     = 16,
  parameter int NUM_HASH   = 3,
  parameter int IDX_W      = 5,
  parameter int STRIDE     = 3,
  parameter int CNT_W      = 2,
  parameter int EX_ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_skip,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic              tag_valid,
  input  logic [ADDR_W-1:0] tag_addr,
  input  logic              tag_hit
);

  logic snp_maybe;
  logic tag_maybe;
  logic excl_hit;
  logic fill_bypass;
  logic fill_on_tag;
  logic incl_clear;
  logic alloc_req;

  smf_include #(
    .ADDR_W(ADDR_W), .NUM_HASH(NUM_HASH), .IDX_W(IDX_W),
    .STRIDE(STRIDE), .CNT_W(CNT_W)
  ) u_incl (
    .clk(clk), .rst_n(rst_n),
    .fill_v(fill_valid), .fill_addr(fill_addr),
    .evict_v(evict_valid), .evict_addr(evict_addr),
    .snp_addr(snp_addr), .tag_addr(tag_addr),
    .snp_maybe(snp_maybe), .tag_maybe(tag_maybe)
  );

  smf_exclude #(
    .ADDR_W(ADDR_W), .ENTRIES(EX_ENTRIES)
  ) u_excl (
    .clk(clk), .rst_n(rst_n),
    .probe_addr(snp_addr), .probe_hit(excl_hit),
    .fill_v(fill_valid), .fill_addr(fill_addr),
    .alloc_req(alloc_req), .alloc_addr(tag_addr)
  );

  assign fill_bypass = fill_valid && (fill_addr == snp_addr);
  assign fill_on_tag = fill_valid && (fill_addr == tag_addr);
  assign incl_clear  = !snp_maybe;
  assign alloc_req   = tag_valid && !tag_hit && tag_maybe && !fill_on_tag;
  assign snp_skip    = snp_valid && !fill_bypass && (incl_clear || excl_hit);

  // R8: a snoop meeting a same-block fill reaches the tags.
  assert_fill_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && fill_bypass) |-> !snp_skip);

  // R11: no skip without a snoop.
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |-> !snp_skip);

endmodule

// File: tb/tb_snoop_miss_filter.sv
`timescale 1ns/1ps
module tb_snoop_miss_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snp_valid = 1'b0;
  logic [15:0] snp_addr = '0;
  logic        snp_skip;
  logic        fill_valid = 1'b0;
  logic [15:0] fill_addr = '0;
  logic        evict_valid = 1'b0;
  logic [15:0] evict_addr = '0;
  logic        tag_valid = 1'b0;
  logic [15:0] tag_addr = '0;
  logic        tag_hit = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  snoop_miss_filter dut (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_skip(snp_skip),
    .fill_valid(fill_valid), .fill_addr(fill_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .tag_valid(tag_valid), .tag_addr(tag_addr), .tag_hit(tag_hit)
  );

  // Operation codes used in the vector table.
  localparam logic [3:0] OP_SNP = 4'd1, OP_FIL = 4'd2, OP_EVI = 4'd3,
                         OP_TMS = 4'd4, OP_THT = 4'd5;
  localparam int NV = 51;
  // {op, block address, expected skip, requirement number}
  localparam logic [31:0] VEC [NV] = '{
    {OP_SNP, 16'h0000, 4'd1, 8'd1},   // R1 empty filter skips
    {OP_SNP, 16'h1234, 4'd1, 8'd1},   // R1
    {OP_FIL, 16'h0000, 4'd0, 8'd0},
    {OP_SNP, 16'h0000, 4'd0, 8'd2},   // R2 resident forwarded
    {OP_SNP, 16'h001F, 4'd1, 8'd3},   // R3 bank 0 index 31 empty
    {OP_SNP, 16'h0800, 4'd0, 8'd3},   // R3 full alias forwarded
    {OP_TMS, 16'h0800, 4'd0, 8'd0},   // slot 0
    {OP_SNP, 16'h0800, 4'd1, 8'd6},   // R6 table hit skips
    {OP_SNP, 16'h0000, 4'd0, 8'd2},   // R2
    {OP_THT, 16'h1000, 4'd0, 8'd0},
    {OP_SNP, 16'h1000, 4'd0, 8'd7},   // R7 hit not recorded
    {OP_FIL, 16'h0800, 4'd0, 8'd0},
    {OP_SNP, 16'h0800, 4'd0, 8'd8},   // R8 fill cleared entry
    {OP_EVI, 16'h0800, 4'd0, 8'd0},
    {OP_EVI, 16'h0000, 4'd0, 8'd0},
    {OP_SNP, 16'h0000, 4'd1, 8'd4},   // R4 evictions cleared counters
    {OP_SNP, 16'h0800, 4'd1, 8'd4},   // R4
    {OP_FIL, 16'h0421, 4'd0, 8'd0},
    {OP_FIL, 16'h0421, 4'd0, 8'd0},
    {OP_SNP, 16'h0421, 4'd0, 8'd2},   // R2
    {OP_EVI, 16'h0421, 4'd0, 8'd0},
    {OP_EVI, 16'h0421, 4'd0, 8'd0},
    {OP_SNP, 16'h0421, 4'd1, 8'd5},   // R5 below saturation counts back
    {OP_FIL, 16'h0000, 4'd0, 8'd0},
    {OP_FIL, 16'h0000, 4'd0, 8'd0},
    {OP_FIL, 16'h0000, 4'd0, 8'd0},
    {OP_EVI, 16'h0000, 4'd0, 8'd0},
    {OP_EVI, 16'h0000, 4'd0, 8'd0},
    {OP_EVI, 16'h0000, 4'd0, 8'd0},
    {OP_SNP, 16'h0000, 4'd0, 8'd5},   // R5 saturated counters stick
    {OP_SNP, 16'h001F, 4'd1, 8'd3},   // R3
    {OP_TMS, 16'h1000, 4'd0, 8'd0},   // slot 1
    {OP_TMS, 16'h1800, 4'd0, 8'd0},   // slot 2
    {OP_TMS, 16'h2000, 4'd0, 8'd0},   // slot 3
    {OP_TMS, 16'h2800, 4'd0, 8'd0},   // slot 0
    {OP_TMS, 16'h3000, 4'd0, 8'd0},   // slot 1, replaces 1000
    {OP_SNP, 16'h1000, 4'd0, 8'd9},   // R9 oldest replaced
    {OP_SNP, 16'h1800, 4'd1, 8'd9},   // R9
    {OP_SNP, 16'h2000, 4'd1, 8'd9},   // R9
    {OP_SNP, 16'h2800, 4'd1, 8'd9},   // R9
    {OP_SNP, 16'h3000, 4'd1, 8'd9},   // R9
    {OP_TMS, 16'h2000, 4'd0, 8'd0},   // already held: no write
    {OP_TMS, 16'h3800, 4'd0, 8'd0},   // slot 2, replaces 1800
    {OP_SNP, 16'h1800, 4'd0, 8'd10},  // R10
    {OP_SNP, 16'h2000, 4'd1, 8'd10},  // R10
    {OP_SNP, 16'h3800, 4'd1, 8'd10},  // R10
    {OP_TMS, 16'h001F, 4'd0, 8'd0},   // summary says absent: no write
    {OP_TMS, 16'h4000, 4'd0, 8'd0},   // slot 3, replaces 2000
    {OP_SNP, 16'h2800, 4'd1, 8'd6},   // R6
    {OP_SNP, 16'h2000, 4'd0, 8'd6},   // R6
    {OP_SNP, 16'h4000, 4'd1, 8'd6}    // R6
  };

  task automatic idle_inputs();
    snp_valid = 0; fill_valid = 0; evict_valid = 0; tag_valid = 0; tag_hit = 0;
  endtask

  task automatic check(input logic got, input logic exp, input int req, input logic [15:0] a);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d addr=%h snp_skip actual=%b expected=%b", req, a, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle_inputs();
      case (VEC[i][31:28])
        OP_SNP: begin snp_valid = 1; snp_addr = VEC[i][27:12]; end
        OP_FIL: begin fill_valid = 1; fill_addr = VEC[i][27:12]; end
        OP_EVI: begin evict_valid = 1; evict_addr = VEC[i][27:12]; end
        OP_TMS: begin tag_valid = 1; tag_addr = VEC[i][27:12]; tag_hit = 0; end
        OP_THT: begin tag_valid = 1; tag_addr = VEC[i][27:12]; tag_hit = 1; end
        default: ;
      endcase
      #1;
      if (VEC[i][31:28] == OP_SNP)
        check(snp_skip, VEC[i][8], int'(VEC[i][7:0]), VEC[i][27:12]);
    end

    // R8: snoop meeting a fill of the same (tabled) block is forwarded.
    @(negedge clk); idle_inputs();
    snp_valid = 1; snp_addr = 16'h2800; fill_valid = 1; fill_addr = 16'h2800;
    #1 check(snp_skip, 1'b0, 8, 16'h2800);
    @(negedge clk); idle_inputs();
    snp_valid = 1; snp_addr = 16'h2800;
    #1 check(snp_skip, 1'b0, 8, 16'h2800);

    // R11: no snoop, no skip.
    @(negedge clk); idle_inputs();
    snp_addr = 16'h1234;
    #1 check(snp_skip, 1'b0, 11, 16'h1234);

    // R1: reset clears both structures.
    @(negedge clk); idle_inputs(); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    snp_valid = 1; snp_addr = 16'h0000;
    #1 check(snp_skip, 1'b1, 1, 16'h0000);
    @(negedge clk); snp_addr = 16'h4000;
    #1 check(snp_skip, 1'b1, 1, 16'h4000);

    // R8: tag miss in the same cycle as a fill of that block records nothing.
    @(negedge clk); idle_inputs(); fill_valid = 1; fill_addr = 16'h0000;
    @(negedge clk); idle_inputs();
    fill_valid = 1; fill_addr = 16'h4800; tag_valid = 1; tag_addr = 16'h4800; tag_hit = 0;
    @(negedge clk); idle_inputs();
    snp_valid = 1; snp_addr = 16'h4800;
    #1 check(snp_skip, 1'b0, 8, 16'h4800);

    @(negedge clk); idle_inputs();
    summary();
  end

endmodule